// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block is the address front end of a synchronous burst memory. On each rising clock edge it looks at three chip enables and two active-low burst-start strobes, one for a processor and one for a cache controller. A start that finds the part selected loads the external address. A start that finds the part not selected turns the output off. A cycle with no start may step a 2-bit burst counter when the active-low advance input is asserted.

The two lowest address bits preset the counter. The upper address bits stay fixed for the whole burst. The order-select input, sampled when the burst starts, picks between two orders. Linear order adds the step count to the low field, modulo 4. Interleaved order XORs the step count into the low field. A new address may be loaded on every cycle, so bursting is optional. The outputs are the current internal address, a flag saying that this address belongs to a selected access, and a flag marking the cycle right after a fresh load.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and right after it, `cur_addr` is 0 and `acc_valid` and `new_load` are 0.
- R2: A start is a low `strb_proc_n` while `ce1_n` is low, or a low `strb_ctrl_n`. When a start meets `ce1_n`=0, `ce2`=1 and `ce3_n`=0 at a rising edge, then after that edge `cur_addr` equals the sampled `addr_in`, and `acc_valid` and `new_load` are 1.
- R3: A low `strb_proc_n` with `ce1_n` high is ignored. The cycle behaves exactly as if that strobe were high.
- R4: A start with any chip enable inactive deselects the block: after the edge `acc_valid` and `new_load` are 0.
- R5: With `ord_sel_n` low at the start, the low two bits of `cur_addr` are the loaded low bits plus the step count, modulo 4.
- R6: With `ord_sel_n` high at the start, the low two bits of `cur_addr` are the loaded low bits XOR the step count.
- R7: In a cycle with no start, a low `adv_n` while `acc_valid` is 1 raises the step count by one. The count wraps from 3 to 0, and bits above bit 1 of `cur_addr` do not change.
- R8: In a cycle with no start and `adv_n` high, `cur_addr`, `acc_valid` and the step count hold their values, and `new_load` goes to 0.
- R9: A start takes priority over advance in the same cycle. Loads may follow one another on consecutive cycles, each taking effect after one edge.
- R10: Changing `ord_sel_n` during a burst has no effect until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_in | input | AW | External address |
| ce1_n | input | 1 | Chip enable 1, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| strb_proc_n | input | 1 | Processor burst-start strobe, active low |
| strb_ctrl_n | input | 1 | Controller burst-start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ord_sel_n | input | 1 | Order select: low linear, high interleaved |
| cur_addr | output | AW | Current internal address |
| acc_valid | output | 1 | Current address belongs to a selected access |
| new_load | output | 1 | Current address was loaded at the last edge |

## Verification
The two functions that can fall in the same cycle are a burst start and a counter advance. Either strobe can be low while `adv_n` is low. Random stimulus keeps both likely in the same cycle, and directed cycles also force this mid-burst. The result is judged by checking that `cur_addr` shows the new external address with a zero step count instead of the advanced one. The same approach covers a processor strobe that arrives with `ce1_n` high while `adv_n` is low. In that case the counter must advance as if no strobe had been given.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          strb_proc_n,
  input  logic          strb_ctrl_n,
  input  logic          adv_n,
  input  logic          ord_sel_n,
  output logic [AW-1:0] cur_addr,
  output logic          acc_valid,
  output logic          new_load
);
  localparam int CW = 2;

  logic [AW-1:0] base_q;
  logic [CW-1:0] step_q;
  logic          lin_q;
  logic          valid_q;
  logic          load_q;

  wire selected  = !ce1_n && ce2 && !ce3_n;
  wire start     = (!strb_proc_n && !ce1_n) || !strb_ctrl_n;
  wire advance   = !start && !adv_n && valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      step_q  <= '0;
      lin_q   <= 1'b0;
      valid_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      load_q <= start && selected;
      if (start) begin
        valid_q <= selected;
        if (selected) begin
          base_q <= addr_in;
          step_q <= '0;
          lin_q  <= !ord_sel_n;
        end
      end else if (advance) begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  logic [CW-1:0] low_lin, low_ilv;
  assign low_lin   = base_q[CW-1:0] + step_q;
  assign low_ilv   = base_q[CW-1:0] ^ step_q;
  assign cur_addr  = {base_q[AW-1:CW], lin_q ? low_lin : low_ilv};
  assign acc_valid = valid_q;
  assign new_load  = load_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr_in,
  input logic          ce1_n,
  input logic          ce2,
  input logic          ce3_n,
  input logic          strb_proc_n,
  input logic          strb_ctrl_n,
  input logic          adv_n,
  input logic          ord_sel_n,
  input logic [AW-1:0] cur_addr,
  input logic          acc_valid,
  input logic          new_load
);
  wire sel   = !ce1_n && ce2 && !ce3_n;
  wire start = (!strb_proc_n && !ce1_n) || !strb_ctrl_n;

  always_comb if (!rst_n) AST_RESET_QUIET: assert (!acc_valid && !new_load); // R1

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start && sel |=> cur_addr == $past(addr_in) && acc_valid && new_load); // R2
  AST_PROC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    strb_ctrl_n && ce1_n && adv_n |=> $stable(cur_addr) && $stable(acc_valid) && !new_load); // R3
  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    start && !sel |=> !acc_valid && !new_load); // R4
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(cur_addr[AW-1:2])); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start && adv_n |=> $stable(cur_addr) && $stable(acc_valid) && !new_load); // R8
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          ce1_n = 1'b1, ce2 = 1'b0, ce3_n = 1'b1;
  logic          strb_proc_n = 1'b1, strb_ctrl_n = 1'b1, adv_n = 1'b1, ord_sel_n = 1'b1;
  logic [AW-1:0] cur_addr;
  logic          acc_valid, new_load;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_step = '0;
  logic          m_lin = 1'b0, m_valid = 1'b0, m_load = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n), .ord_sel_n(ord_sel_n),
    .cur_addr(cur_addr), .acc_valid(acc_valid), .new_load(new_load));

  function automatic logic [AW-1:0] exp_addr();
    logic [1:0] lo;
    lo = m_lin ? m_base[1:0] + m_step : m_base[1:0] ^ m_step;
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic chk(string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string areq, string vreq);
    chk(areq, "cur_addr", cur_addr, exp_addr());
    chk(vreq, "acc_valid", AW'(acc_valid), AW'(m_valid));
    chk(vreq, "new_load", AW'(new_load), AW'(m_load));
  endtask

  task automatic cyc(logic [AW-1:0] a, logic c1, logic c2, logic c3, logic sp, logic sc,
                     logic av, logic od, string areq, string vreq);
    logic st, sl;
    addr_in = a; ce1_n = c1; ce2 = c2; ce3_n = c3;
    strb_proc_n = sp; strb_ctrl_n = sc; adv_n = av; ord_sel_n = od;
    st = (!sp && !c1) || !sc;
    sl = !c1 && c2 && !c3;
    @(posedge clk);
    m_load = st && sl;
    if (st) begin
      m_valid = sl;
      if (sl) begin m_base = a; m_step = 2'd0; m_lin = !od; end
    end else if (!av && m_valid) begin
      m_step = m_step + 2'd1;
    end
    @(negedge clk);
    check_all(areq, vreq);
  endtask

  function automatic string tag_for(logic c1, logic c2, logic c3, logic sp, logic sc, logic av, logic od,
                                    output string vreq);
    logic st, sl;
    st = (!sp && !c1) || !sc;
    sl = !c1 && c2 && !c3;
    if (st && sl) begin vreq = "R2"; return av ? "R2" : "R9"; end
    if (st) begin vreq = "R4"; return "R4"; end
    if (!sp) vreq = "R3"; else vreq = av ? "R8" : "R7";
    if (!av && m_valid) return m_lin ? "R5" : "R6";
    return vreq;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1", "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1", "R1");

    // linear burst from low field 3 with wrap
    cyc(20'hABCD3, 0, 1, 0, 0, 1, 1, 0, "R2", "R2");
    cyc(20'h00000, 0, 1, 0, 1, 1, 0, 1, "R5", "R7");
    chk("R5", "wrap", cur_addr, 20'hABCD0);
    cyc(20'h00000, 0, 1, 0, 1, 1, 0, 1, "R10", "R7");
    chk("R10", "order fixed", cur_addr, 20'hABCD1);
    cyc(20'h00000, 0, 1, 0, 1, 1, 0, 1, "R5", "R7");
    cyc(20'h00000, 0, 1, 0, 1, 1, 0, 1, "R7", "R7");
    chk("R7", "count wrap", cur_addr, 20'hABCD3);
    cyc(20'h00000, 0, 1, 0, 1, 1, 1, 1, "R8", "R8");
    // interleaved burst from 2 via controller strobe with ce1 high? no: all enables on
    cyc(20'h12342, 0, 1, 0, 1, 0, 1, 1, "R2", "R2");
    cyc(20'h00000, 1, 1, 0, 1, 1, 0, 0, "R6", "R7");
    chk("R6", "ilv step1", cur_addr, 20'h12343);
    cyc(20'h00000, 1, 1, 0, 1, 1, 0, 0, "R6", "R7");
    chk("R6", "ilv step2", cur_addr, 20'h12340);
    // processor strobe with ce1 high is ignored, advance still steps
    cyc(20'h55555, 1, 1, 0, 0, 1, 0, 0, "R3", "R3");
    chk("R3", "ignored strobe", cur_addr, 20'h12341);
    // start and advance in the same cycle
    cyc(20'h77771, 0, 1, 0, 0, 1, 0, 0, "R9", "R9");
    chk("R9", "load wins", cur_addr, 20'h77771);
    cyc(20'h88882, 0, 1, 0, 1, 0, 0, 1, "R9", "R9");
    chk("R9", "back to back", cur_addr, 20'h88882);
    // deselect through controller strobe with ce2 low
    cyc(20'h99999, 0, 0, 0, 1, 0, 1, 0, "R4", "R4");
    chk("R4", "deselect valid", AW'(acc_valid), '0);
    cyc(20'h00000, 0, 1, 0, 1, 1, 0, 0, "R8", "R8");

    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic c1, c2, c3, sp, sc, av, od;
      string ar, vr;
      c1 = ($urandom % 5) == 0;
      c2 = ($urandom % 6) != 0;
      c3 = ($urandom % 6) == 0;
      sp = ($urandom % 4) != 0;
      sc = ($urandom % 5) != 0;
      av = ($urandom % 3) == 0;
      od = $urandom % 2;
      ar = tag_for(c1, c2, c3, sp, sc, av, od, vr);
      cyc(AW'($urandom), c1, c2, c3, sp, sc, av, od, ar, vr);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule